// File: doc/BRIEF.md
# Per-CPU Banked Interrupt Priority Store

This block holds an 8-bit priority for every interrupt ID of an interrupt controller. Software reaches it through a small memory-mapped port. A request carries a byte offset, an access size of one, two or four bytes, write data and the ID of the CPU that issued it. The byte offset is the interrupt ID, so a multi-byte access covers a run of consecutive IDs.

The lowest IDs are private to each CPU: the software-generated and per-processor peripheral interrupts. For these IDs every CPU owns its own copy of the priority byte, and the requester's CPU ID picks which copy is used. All higher IDs share one copy that every CPU sees.

Every request gets a response on the following cycle. The response carries the read data and an error flag. The block also presents, for each CPU, the complete priority table as that CPU sees it, so that a priority arbiter can read it.

Top module: `prio_bank_top`

## Requirements
- R1: After reset every banked and shared priority byte is zero, `prio_view_o` is all zero and `rsp_valid` is low.
- R2: The byte offset `req_addr` equals the interrupt ID. A one-byte access reads or writes only that ID's priority, and the value appears in `rsp_rdata[7:0]` with the upper bits zero.
- R3: A two- or four-byte access covers IDs `req_addr`, `req_addr+1`, and so on. ID `req_addr+k` sits in `rsp_rdata`/`req_wdata` bits `8k+7:8k`, and data bits above the access size read as zero.
- R4: IDs below `BANKED_IDS` (default 32) are banked. A write stores into the copy of CPU `req_cpu` only, and a read returns that CPU's copy. Other CPUs' copies are unaffected.
- R5: IDs from `BANKED_IDS` up to `NUM_IDS-1` share one copy, so a write from any CPU is seen by reads from every CPU.
- R6: When `req_size` is not 1, 2 or 4, the response has `rsp_err` high and `rsp_rdata` zero, and no priority changes.
- R7: When `req_addr + req_size` exceeds `NUM_IDS`, the response has `rsp_err` high and `rsp_rdata` zero, and no priority changes.
- R8: Every request cycle produces exactly one response cycle, with `rsp_valid` high on the next cycle. Write responses and idle cycles carry `rsp_rdata` zero, and a cycle without a request is followed by `rsp_valid` low.
- R9: The starting ID alone selects banked or shared storage. In an access that starts below `BANKED_IDS`, bytes whose ID is `BANKED_IDS` or more are dropped on write and read as zero, with no error. The shared bytes at those IDs keep their value.
- R10: `prio_view_o[(c*NUM_IDS+i)*8 +: 8]` shows the priority of ID `i` as CPU `c` sees it: the banked copy of CPU `c` below `BANKED_IDS`, and the shared copy above.
- R11: A read request never changes any priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (10) | Byte offset, which is the starting interrupt ID |
| req_size | input | 3 | Access size in bytes; legal values 1, 2, 4 |
| req_cpu | input | CPU_W (2) | ID of the requesting CPU |
| req_wdata | input | 32 | Write data, lowest ID in bits 7:0 |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_rdata | output | 32 | Read data, zero for writes, errors and idle cycles |
| rsp_err | output | 1 | Illegal size or access past the last ID |
| prio_view_o | output | NUM_CPUS*NUM_IDS*8 | Per-CPU view of all priorities |

## Verification
The assertions assume that `req_cpu` names an implemented CPU. They also assume that the request fields are steady for the whole cycle in which `req_valid` is high. The bench only issues CPU IDs 0 to 3 with the default four CPUs. It drives every request field on the falling edge, so the fields are settled well before the rising edge that captures them. Illegal sizes and out-of-range offsets are issued on purpose, because the block must absorb them and flag them.

// File: rtl/prio_bank_pkg.sv
package prio_bank_pkg;

    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int DATA_W = LANES * BYTE_W;

    typedef logic [BYTE_W-1:0] prio_t;

    // per-request decode result
    typedef struct packed {
        logic             err;
        logic [LANES-1:0] lane_bank;
        logic [LANES-1:0] lane_shared;
    } dec_t;

    function automatic logic size_legal(input logic [2:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

endpackage

// File: rtl/prio_access_decode.sv
module prio_access_decode
    import prio_bank_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int NUM_IDS    = 64,
    parameter int BANKED_IDS = 32
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic [2:0]                    size,
    output dec_t                          dec,
    output logic [LANES-1:0][ADDR_W-1:0]  lane_id
);

    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] end_ext;
    logic             start_banked;

    always_comb begin
        end_ext      = {1'b0, addr} + EXT_W'(size);
        dec.err      = !size_legal(size) || (end_ext > EXT_W'(NUM_IDS));
        start_banked = addr < ADDR_W'(BANKED_IDS);
        for (int k = 0; k < LANES; k++) begin
            lane_id[k]         = addr + ADDR_W'(k);
            dec.lane_bank[k]   = !dec.err && (3'(k) < size) && start_banked
                                 && (lane_id[k] < ADDR_W'(BANKED_IDS));
            dec.lane_shared[k] = !dec.err && (3'(k) < size) && !start_banked;
        end
    end

endmodule

// File: rtl/prio_store.sv
module prio_store
    import prio_bank_pkg::*;
#(
    parameter int NUM_CPUS   = 4,
    parameter int NUM_IDS    = 64,
    parameter int BANKED_IDS = 32,
    parameter int ADDR_W     = 10,
    parameter int CPU_W      = 2
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [CPU_W-1:0]                   cpu,
    input  logic [LANES-1:0][ADDR_W-1:0]       lane_id,
    input  logic [LANES-1:0]                   lane_bank,
    input  logic [LANES-1:0]                   lane_shared,
    input  logic [DATA_W-1:0]                  wdata,
    output logic [DATA_W-1:0]                  rdata,
    output logic [NUM_CPUS*NUM_IDS*BYTE_W-1:0] view
);

    localparam int SHARED_IDS = NUM_IDS - BANKED_IDS;
    localparam int BK_W       = (BANKED_IDS > 1) ? $clog2(BANKED_IDS) : 1;
    localparam int SH_W       = (SHARED_IDS > 1) ? $clog2(SHARED_IDS) : 1;

    prio_t bank_q   [NUM_CPUS][BANKED_IDS];
    prio_t shared_q [SHARED_IDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CPUS; c++)
                for (int i = 0; i < BANKED_IDS; i++)
                    bank_q[c][i] <= '0;
            for (int i = 0; i < SHARED_IDS; i++)
                shared_q[i] <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < LANES; k++) begin
                if (lane_bank[k])
                    bank_q[cpu][BK_W'(lane_id[k])] <= wdata[k*BYTE_W +: BYTE_W];
                if (lane_shared[k])
                    shared_q[SH_W'(lane_id[k] - ADDR_W'(BANKED_IDS))]
                        <= wdata[k*BYTE_W +: BYTE_W];
            end
        end
    end

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            if (lane_bank[k])
                rdata[k*BYTE_W +: BYTE_W] = bank_q[cpu][BK_W'(lane_id[k])];
            else if (lane_shared[k])
                rdata[k*BYTE_W +: BYTE_W] =
                    shared_q[SH_W'(lane_id[k] - ADDR_W'(BANKED_IDS))];
            else
                rdata[k*BYTE_W +: BYTE_W] = '0;
        end
    end

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
            if (i < BANKED_IDS) begin : g_bank
                assign view[(c*NUM_IDS+i)*BYTE_W +: BYTE_W] = bank_q[c][i];
            end else begin : g_shared
                assign view[(c*NUM_IDS+i)*BYTE_W +: BYTE_W] = shared_q[i-BANKED_IDS];
            end
        end
    end

    // a write with no lane enabled must leave every priority alone
    AST_NO_LANE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (lane_bank == '0 && lane_shared == '0) |=> $stable(view)); // R9

endmodule

// File: rtl/prio_bank_top.sv
module prio_bank_top
    import prio_bank_pkg::*;
#(
    parameter int NUM_CPUS   = 4,
    parameter int NUM_IDS    = 64,
    parameter int BANKED_IDS = 32,
    parameter int ADDR_W     = 10,
    localparam int CPU_W     = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    localparam int VIEW_W    = NUM_CPUS * NUM_IDS * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [CPU_W-1:0]  req_cpu,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic [VIEW_W-1:0] prio_view_o
);

    dec_t                         dec;
    logic [LANES-1:0][ADDR_W-1:0] lane_id;
    logic [DATA_W-1:0]            rd_comb;
    logic                         wr_en;

    assign wr_en = req_valid && req_write;

    prio_access_decode #(
        .ADDR_W     (ADDR_W),
        .NUM_IDS    (NUM_IDS),
        .BANKED_IDS (BANKED_IDS)
    ) decode_i (
        .addr    (req_addr),
        .size    (req_size),
        .dec     (dec),
        .lane_id (lane_id)
    );

    prio_store #(
        .NUM_CPUS   (NUM_CPUS),
        .NUM_IDS    (NUM_IDS),
        .BANKED_IDS (BANKED_IDS),
        .ADDR_W     (ADDR_W),
        .CPU_W      (CPU_W)
    ) store_i (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .cpu         (req_cpu),
        .lane_id     (lane_id),
        .lane_bank   (dec.lane_bank),
        .lane_shared (dec.lane_shared),
        .wdata       (req_wdata),
        .rdata       (rd_comb),
        .view        (prio_view_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && dec.err;
            rsp_rdata <= (req_valid && !req_write) ? rd_comb : '0;
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R8
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && rsp_rdata == '0)); // R8
    AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_rdata == '0); // R6
    AST_ERR_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && dec.err) |=> $stable(prio_view_o)); // R7
    AST_READ_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> $stable(prio_view_o)); // R11

endmodule

// File: tb/prio_bank_top_tb_top.sv
module prio_bank_top_tb_top;

    localparam int NC = 4;
    localparam int NI = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [2:0]  req_size = '0;
    logic [1:0]  req_cpu = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic [NC*NI*8-1:0] prio_view_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    prio_bank_top dut_i (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_size    (req_size),
        .req_cpu     (req_cpu),
        .req_wdata   (req_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .rsp_err     (rsp_err),
        .prio_view_o (prio_view_o)
    );

    function automatic logic [7:0] view_of(input int c, input int i);
        return prio_view_o[(c*NI+i)*8 +: 8];
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic access(input logic wr, input int addr, input int sz,
                          input int cpu, input logic [31:0] wd,
                          output logic [31:0] rd, output logic er,
                          output logic vl);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = 10'(addr);
        req_size  = 3'(sz);
        req_cpu   = 2'(cpu);
        req_wdata = wd;
        @(negedge clk);
        rd = rsp_rdata;
        er = rsp_err;
        vl = rsp_valid;
        req_valid = 1'b0;
    endtask

    task automatic test_reset();
        int nz = 0;
        chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        for (int c = 0; c < NC; c++)
            for (int i = 0; i < NI; i++)
                if (view_of(c, i) != 8'h00) nz++;
        chk("R1", "nonzero view bytes", nz, 0);
    endtask

    task automatic test_byte_shared();
        logic [31:0] rd; logic er, vl;
        access(1'b1, 40, 1, 0, 32'h0000_00A5, rd, er, vl);
        chk("R8", "write rsp_valid", 32'(vl), 32'd1);
        chk("R8", "write rsp_rdata", rd, 32'd0);
        access(1'b0, 40, 1, 2, 32'h0, rd, er, vl);
        chk("R2", "byte read id40 cpu2", rd, 32'h0000_00A5);
        chk("R5", "shared err", 32'(er), 32'd0);
        chk("R10", "view cpu3 id40", 32'(view_of(3, 40)), 32'hA5);
        chk("R2", "neighbour id41 untouched", 32'(view_of(0, 41)), 32'h00);
        @(negedge clk);
        chk("R8", "idle rsp_valid", 32'(rsp_valid), 32'd0);
    endtask

    task automatic test_wide_lanes();
        logic [31:0] rd; logic er, vl;
        access(1'b1, 48, 4, 1, 32'h4433_2211, rd, er, vl);
        access(1'b0, 49, 1, 3, 32'h0, rd, er, vl);
        chk("R3", "id49 byte lane", rd, 32'h0000_0022);
        access(1'b0, 50, 2, 0, 32'h0, rd, er, vl);
        chk("R3", "halfword at 50", rd, 32'h0000_4433);
        access(1'b0, 48, 4, 2, 32'h0, rd, er, vl);
        chk("R3", "word at 48", rd, 32'h4433_2211);
    endtask

    task automatic test_banked();
        logic [31:0] rd; logic er, vl;
        access(1'b1, 4, 4, 1, 32'hDDCC_BBAA, rd, er, vl);
        access(1'b0, 4, 4, 2, 32'h0, rd, er, vl);
        chk("R4", "other cpu bank", rd, 32'h0);
        access(1'b0, 4, 4, 1, 32'h0, rd, er, vl);
        chk("R4", "own cpu bank", rd, 32'hDDCC_BBAA);
        chk("R10", "view cpu1 id5", 32'(view_of(1, 5)), 32'hBB);
        chk("R10", "view cpu0 id5", 32'(view_of(0, 5)), 32'h00);
        access(1'b1, 20, 2, 3, 32'hFFFF_1234, rd, er, vl);
        access(1'b0, 20, 2, 3, 32'h0, rd, er, vl);
        chk("R4", "halfword bank cpu3", rd, 32'h0000_1234);
    endtask

    task automatic test_bad_size();
        logic [31:0] rd; logic er, vl;
        access(1'b1, 36, 1, 0, 32'h11, rd, er, vl);
        access(1'b1, 36, 3, 0, 32'h99, rd, er, vl);
        chk("R6", "size3 err", 32'(er), 32'd1);
        access(1'b0, 36, 1, 0, 32'h0, rd, er, vl);
        chk("R6", "id36 after bad write", rd, 32'h11);
        access(1'b0, 36, 0, 0, 32'h0, rd, er, vl);
        chk("R6", "size0 err", 32'(er), 32'd1);
        chk("R6", "size0 rdata", rd, 32'h0);
    endtask

    task automatic test_range();
        logic [31:0] rd; logic er, vl;
        access(1'b1, 62, 1, 0, 32'h5A, rd, er, vl);
        chk("R7", "in-range write err", 32'(er), 32'd0);
        access(1'b1, 62, 4, 0, 32'h7777_7777, rd, er, vl);
        chk("R7", "overrun write err", 32'(er), 32'd1);
        access(1'b0, 62, 2, 1, 32'h0, rd, er, vl);
        chk("R7", "ids 62..63 kept", rd, 32'h0000_005A);
        access(1'b0, 200, 1, 0, 32'h0, rd, er, vl);
        chk("R7", "far offset err", 32'(er), 32'd1);
        chk("R7", "far offset rdata", rd, 32'h0);
    endtask

    task automatic test_cross();
        logic [31:0] rd; logic er, vl;
        access(1'b1, 30, 4, 0, 32'h4433_2211, rd, er, vl);
        chk("R9", "crossing write err", 32'(er), 32'd0);
        access(1'b0, 30, 4, 0, 32'h0, rd, er, vl);
        chk("R9", "crossing read", rd, 32'h0000_2211);
        access(1'b0, 32, 2, 1, 32'h0, rd, er, vl);
        chk("R9", "shared 32..33 untouched", rd, 32'h0);
        chk("R9", "view cpu2 id31", 32'(view_of(2, 31)), 32'h00);
    endtask

    task automatic test_read_no_effect();
        logic [31:0] rd; logic er, vl;
        logic [NC*NI*8-1:0] snap;
        snap = prio_view_o;
        access(1'b0, 4, 4, 1, 32'hFFFF_FFFF, rd, er, vl);
        access(1'b0, 40, 4, 0, 32'hFFFF_FFFF, rd, er, vl);
        chk("R11", "view unchanged by reads", 32'(snap == prio_view_o), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_byte_shared();
        test_wide_lanes();
        test_banked();
        test_bad_size();
        test_range();
        test_cross();
        test_read_no_effect();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule